// File: doc/BRIEF.md
# Single-Wire Bus Pulse Timing Classifier

This block times the pulses on a single-wire, variable-pulse-width serial bus and names each pulse length as it passes a programmed threshold. The sampled bus level is brought through a two-flop synchronizer. A symbol counter restarts on every synchronized edge and counts clock cycles. Each time the counter takes a new value, it is compared against a bank of twelve programmable timing values. Four of these values apply only to dominant (level 1) pulses, four only to recessive (level 0) pulses, and four receive-side values apply to both. One bank serves normal speed and a second bank serves quadruple speed, chosen by a mode input.

Matches are resolved by a fixed priority, so at most one symbol strobe is raised per counter value. The counter saturates at its maximum and holds there. The block also tracks when the local transmitter may begin a start of frame, in one of two ways:
- the interframe spacing value is reached; or
- the end-of-frame value has been seen and another node then drives a rising edge.

A start-of-frame-sent strobe restarts the counter. So does any change of speed mode, which means a late switch between banks cannot leave the counter stuck beyond the new bank's thresholds.

Top module: `j1850_symbol_timer`

## Requirements
- R1: `bus_i` passes through two synchronizing flops. The symbol counter restarts at 0 on every edge of the synchronized level and otherwise adds one per clock. The pulse being timed is dominant when the synchronized level is 1.
- R2: For a dominant pulse the values are tried in this order, and the first equal value wins: start (field 0), dominant short (1), dominant long (2), break (3), receive minimum (8), receive short (9), receive long (10), end of frame (11).
- R3: For a recessive pulse the order is: recessive short (4), recessive long (5), in-frame response (6), interframe spacing (7), then fields 8, 9, 10 and 11.
- R4: `sym_o` is one-hot or zero. Bit k is high for one cycle, in the cycle after the counter held a new value equal to field k and no higher-priority field matched that value.
- R5: The counter saturates at 2^CNT_W-1 and holds. A field equal to the maximum produces exactly one strobe per pulse.
- R6: `sof_sent_i` restarts the counter and clears `tx_ok_o` and `idle_o` on the next edge.
- R7: `speed_4x_i`=0 selects `prm_1x_i` and 1 selects `prm_4x_i`. Field k occupies bits [k*CNT_W +: CNT_W].
- R8: Any change of `speed_4x_i` restarts the counter and clears `tx_ok_o` and `idle_o`.
- R9: A match of field 7 (interframe spacing) sets `tx_ok_o`.
- R10: On a synchronized rising edge, `tx_ok_o` takes the value of `idle_o`. A rising edge without a prior end of frame therefore clears `tx_ok_o`.
- R11: `idle_o` sets when field 11 matches during a recessive pulse and clears on any bus edge.
- R12: During reset, `sym_o`, `tx_ok_o` and `idle_o` are 0 and the bus level is taken as recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 1 | Raw bus level, 1 = dominant |
| speed_4x_i | input | 1 | Speed bank select, 1 = quadruple speed |
| sof_sent_i | input | 1 | Local start of frame sent, one-cycle strobe |
| prm_1x_i | input | 12*CNT_W | Normal-speed timing values, field k at [k*CNT_W +: CNT_W] |
| prm_4x_i | input | 12*CNT_W | Quadruple-speed timing values, same layout |
| sym_o | output | 12 | Detected symbol strobe, one-hot or zero |
| tx_ok_o | output | 1 | Start of frame permitted |
| idle_o | output | 1 | End of frame seen, bus idle |

## Verification
The assertions watch these properties on every cycle:
- the strobe vector stays one-hot or zero;
- the counter restarts after any restart cause and holds once saturated;
- a start-of-frame strobe or mode change leaves both flags clear;
- idle rises only alongside an end-of-frame strobe and only on a recessive level.

The priority order under equal values, the exact cycle of each strobe, the arbitration rule after an end of frame, and recovery from a late bank switch depend on pulse sequences. Only the bench's reference model and its scenarios show those.

// File: rtl/j1850_sym_pkg.sv
package j1850_sym_pkg;
  localparam int NSYM  = 12;
  localparam int NRANK = 8;
  localparam int SYM_A_START = 0;
  localparam int SYM_A_SHORT = 1;
  localparam int SYM_A_LONG  = 2;
  localparam int SYM_A_BREAK = 3;
  localparam int SYM_P_SHORT = 4;
  localparam int SYM_P_LONG  = 5;
  localparam int SYM_P_IFR   = 6;
  localparam int SYM_P_IFS   = 7;
  localparam int SYM_R_MIN   = 8;
  localparam int SYM_R_SHORT = 9;
  localparam int SYM_R_LONG  = 10;
  localparam int SYM_R_EOF   = 11;

  // rank k of the priority scan -> field index
  function automatic int rank_field(input logic dominant, input int k);
    if (k >= 4) return k + 4;
    return dominant ? k : k + 4;
  endfunction
endpackage

// File: rtl/j1850_edge_sync.sv
module j1850_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_i,
  output logic lvl_o,
  output logic edge_o,
  output logic rise_o
);
  logic s1_q, s2_q, lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      s1_q  <= bus_i;
      s2_q  <= s1_q;
      lvl_q <= s2_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign edge_o = s2_q ^ lvl_q;
  assign rise_o = s2_q & ~lvl_q;
endmodule

// File: rtl/j1850_sym_counter.sv
module j1850_sym_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fresh_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else if (restart_i) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else if (cnt_q != CMAX) begin
      cnt_q   <= cnt_q + 1'b1;
      fresh_q <= 1'b1;
    end else begin
      fresh_q <= 1'b0; // saturated: value already evaluated
    end
  end

  assign cnt_o   = cnt_q;
  assign fresh_o = fresh_q;

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_o == '0); // R1
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CMAX && !restart_i) |=> cnt_o == CMAX); // R5
  AST_STALE_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_o |-> cnt_o == CMAX); // R5
endmodule

// File: rtl/j1850_sym_match.sv
module j1850_sym_match
  import j1850_sym_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  fresh_i,
  input  logic                  dominant_i,
  input  logic [NSYM*CNT_W-1:0] bank_i,
  output logic [NSYM-1:0]       hit_o
);
  logic [NSYM-1:0] eq;

  for (genvar g = 0; g < NSYM; g++) begin : g_cmp
    assign eq[g] = (cnt_i == bank_i[g*CNT_W +: CNT_W]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    hit_o = '0;
    for (int k = 0; k < NRANK; k++) begin
      if (fresh_i && !found && eq[rank_field(dominant_i, k)]) begin
        hit_o[rank_field(dominant_i, k)] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/j1850_symbol_timer.sv
module j1850_symbol_timer
  import j1850_sym_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_i,
  input  logic                  speed_4x_i,
  input  logic                  sof_sent_i,
  input  logic [NSYM*CNT_W-1:0] prm_1x_i,
  input  logic [NSYM*CNT_W-1:0] prm_4x_i,
  output logic [NSYM-1:0]       sym_o,
  output logic                  tx_ok_o,
  output logic                  idle_o
);
  logic                  lvl, bus_edge, bus_rise;
  logic                  mode_q, mode_chg, restart;
  logic [CNT_W-1:0]      cnt;
  logic                  fresh;
  logic [NSYM*CNT_W-1:0] bank;
  logic [NSYM-1:0]       hit, sym_q;
  logic                  tx_q, idle_q;

  j1850_edge_sync u_sync (
    .clk_i, .rst_ni, .bus_i,
    .lvl_o(lvl), .edge_o(bus_edge), .rise_o(bus_rise)
  );

  assign mode_chg = speed_4x_i ^ mode_q;
  assign restart  = bus_edge | sof_sent_i | mode_chg;
  assign bank     = mode_q ? prm_4x_i : prm_1x_i;

  j1850_sym_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .cnt_o(cnt), .fresh_o(fresh)
  );

  j1850_sym_match #(.CNT_W(CNT_W)) u_match (
    .cnt_i(cnt), .fresh_i(fresh), .dominant_i(lvl), .bank_i(bank), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      sym_q  <= '0;
      tx_q   <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      mode_q <= speed_4x_i;
      sym_q  <= hit;
      if (sof_sent_i || mode_chg)  tx_q <= 1'b0;
      else if (hit[SYM_P_IFS])     tx_q <= 1'b1;
      else if (bus_rise)           tx_q <= idle_q; // contend after end of frame
      if (sof_sent_i || mode_chg || bus_edge) idle_q <= 1'b0;
      else if (hit[SYM_R_EOF] && !lvl)        idle_q <= 1'b1;
    end
  end

  assign sym_o   = sym_q;
  assign tx_ok_o = tx_q;
  assign idle_o  = idle_q;

  AST_SYM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sym_o)); // R4
  AST_SOF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_sent_i |=> (!tx_ok_o && !idle_o)); // R6
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_4x_i != mode_q) |=> (!tx_ok_o && !idle_o)); // R8
  AST_IDLE_FROM_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> sym_o[SYM_R_EOF]); // R11
  AST_IDLE_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !lvl); // R11
endmodule

// File: tb/sim_j1850_symbol_timer.sv
`timescale 1ns/1ps
module sim_j1850_symbol_timer;
  localparam int CW = 8;
  localparam int NS = 12;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus = 1'b0, mode = 1'b0, sof = 1'b0;
  logic [NS*CW-1:0] p1, p4;
  logic [NS-1:0] sym_o;
  logic tx_ok_o, idle_o;

  int checks = 0, errors = 0;
  int seen [NS];

  always #5 clk = ~clk;

  j1850_symbol_timer #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .speed_4x_i(mode), .sof_sent_i(sof),
    .prm_1x_i(p1), .prm_4x_i(p4), .sym_o(sym_o), .tx_ok_o(tx_ok_o), .idle_o(idle_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fld(input logic [NS*CW-1:0] b, input int id);
    return int'(b[id*CW +: CW]);
  endfunction

  // behavioural reference model
  int m_s1, m_s2, m_lvl, m_cnt, m_fresh, m_mode, m_sym, m_tx, m_idle;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_cnt = 0; m_fresh = 1;
      m_mode = 0; m_sym = -1; m_tx = 0; m_idle = 0;
    end else begin
      int hit;
      bit edg, rise, mchg, rst_cnt;
      edg  = (m_s2 != m_lvl);
      rise = edg && (m_s2 == 1);
      mchg = (int'(mode) != m_mode);
      hit  = -1;
      if (m_fresh == 1) begin
        int order [$];
        if (m_lvl == 1) order = '{0, 1, 2, 3, 8, 9, 10, 11};
        else            order = '{4, 5, 6, 7, 8, 9, 10, 11};
        foreach (order[i])
          if (hit < 0 && m_cnt == fld(m_mode == 1 ? p4 : p1, order[i])) hit = order[i];
      end
      rst_cnt = edg || sof || mchg;
      if (sof || mchg) m_tx = 0;
      else if (hit == 7) m_tx = 1;
      else if (rise) m_tx = m_idle;
      if (sof || mchg || edg) m_idle = 0;
      else if (hit == 11 && m_lvl == 0) m_idle = 1;
      m_fresh = (rst_cnt || m_cnt < CMAX) ? 1 : 0;
      if (rst_cnt) m_cnt = 0; else if (m_cnt < CMAX) m_cnt = m_cnt + 1;
      m_sym = hit;
      m_lvl = m_s2; m_s2 = m_s1; m_s1 = int'(bus);
      m_mode = int'(mode);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_sym;
      exp_sym = (m_sym >= 0) ? (1 << m_sym) : 0;
      chk(int'(sym_o) == exp_sym, "R4 sym_o vs model", int'(sym_o), exp_sym);
      chk(int'(tx_ok_o) == m_tx, "R9/R10 tx_ok_o vs model", int'(tx_ok_o), m_tx);
      chk(int'(idle_o) == m_idle, "R11 idle_o vs model", int'(idle_o), m_idle);
      for (int k = 0; k < NS; k++) if (sym_o[k]) seen[k]++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic clr();
    for (int k = 0; k < NS; k++) seen[k] = 0;
  endtask

  task automatic setp(input bit fast, input int id, input int v);
    if (fast) p4[id*CW +: CW] = CW'(v);
    else      p1[id*CW +: CW] = CW'(v);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v1 [NS] = '{30, 6, 12, 40, 6, 12, 20, 50, 3, 9, 15, 25};
    int v4 [NS] = '{15, 3, 7, 20, 3, 7, 10, 24, 2, 5, 8, 13};
    for (int k = 0; k < NS; k++) begin setp(0, k, v1[k]); setp(1, k, v4[k]); end
    clr();
    cyc(5);
    chk(sym_o == '0 && !tx_ok_o && !idle_o, "R12 reset state", int'(sym_o), 0);
    rst_n = 1'b1;
    cyc(2);
    chk(!tx_ok_o, "R12 tx_ok_o after reset", int'(tx_ok_o), 0);

    // long recessive: interframe spacing and end of frame
    cyc(70);
    chk(tx_ok_o, "R9 tx_ok_o after spacing", int'(tx_ok_o), 1);
    chk(idle_o, "R11 idle_o after end of frame", int'(idle_o), 1);
    chk(seen[7] == 1, "R3 spacing strobe count", seen[7], 1);

    // rising edge from another node after end of frame
    clr(); bus = 1'b1;
    cyc(6);
    chk(tx_ok_o, "R10 tx_ok_o kept on rise after idle", int'(tx_ok_o), 1);
    chk(!idle_o, "R11 idle_o cleared by edge", int'(idle_o), 0);
    cyc(14);
    chk(seen[1] == 1 && seen[2] == 1, "R1 dominant short+long", seen[1] + seen[2], 2);
    chk(seen[0] == 0, "R1 start not reached", seen[0], 0);

    // short recessive gap, then rising edge without end of frame
    bus = 1'b0; cyc(10); bus = 1'b1; cyc(6);
    chk(!tx_ok_o, "R10 tx_ok_o cleared on rise without idle", int'(tx_ok_o), 0);

    // equal values: receive short == short thresholds
    setp(0, 9, 6);
    clr(); bus = 1'b0; cyc(14);
    chk(seen[4] == 1, "R3 recessive short wins", seen[4], 1);
    chk(seen[9] == 0, "R3 receive short masked", seen[9], 0);
    clr(); bus = 1'b1; cyc(14);
    chk(seen[1] == 1, "R2 dominant short wins", seen[1], 1);
    chk(seen[9] == 0, "R2 receive short masked", seen[9], 0);
    setp(0, 9, 9);

    // saturation with a field at the maximum
    setp(0, 3, CMAX);
    bus = 1'b0; cyc(12); clr(); bus = 1'b1; cyc(300);
    chk(seen[3] == 1, "R5 single strobe at max", seen[3], 1);
    chk(seen[0] == 1, "R5 start strobe once", seen[0], 1);
    setp(0, 3, 40);

    // start of frame sent
    bus = 1'b0; cyc(70);
    chk(tx_ok_o, "R9 tx_ok_o before sof", int'(tx_ok_o), 1);
    sof = 1'b1; cyc(1); sof = 1'b0; cyc(2);
    chk(!tx_ok_o && !idle_o, "R6 sof clears flags", int'(tx_ok_o), 0);
    cyc(40);
    chk(!tx_ok_o, "R6 counter restarted by sof", int'(tx_ok_o), 0);
    cyc(20);
    chk(tx_ok_o, "R6 spacing reached again", int'(tx_ok_o), 1);

    // late switch to fast bank: counter already past its spacing value
    mode = 1'b1; cyc(2);
    chk(!tx_ok_o, "R8 mode change clears tx_ok_o", int'(tx_ok_o), 0);
    cyc(18);
    chk(!tx_ok_o, "R8 counter restarted by mode change", int'(tx_ok_o), 0);
    cyc(12);
    chk(tx_ok_o, "R7 fast spacing reached", int'(tx_ok_o), 1);
    clr(); bus = 1'b1; cyc(12);
    chk(seen[2] == 1, "R7 fast dominant long", seen[2], 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule